// File: doc/BRIEF.md
# Register Dependency Matrix Scoreboard

This block sits between an in-order issue stage and a small pool of function units. It decides when each in-flight unit may read its source registers and when it may commit its result to the register file. The order of register hazards is kept as a graph of single-bit edges between units, not as per-register tags. A unit that takes one cycle and a unit that takes a hundred are handled the same way. A grant depends only on whether the results it waits for have been committed. It never depends on how long a unit has been running.

Each issue request names a unit kind, a destination register and two source registers. The block picks a free unit of that kind and records two kinds of edge. A read edge points to every older unit that still has to write one of the new unit's sources. A write edge points to every older unit that has not yet read the new unit's destination. A unit is granted its read once its read edges are gone. It is granted its write once it has read, reports its result ready, has no write edges left and is not held off by its per-unit write-hold input. Speculation logic outside the block drives that input. A write commit clears every edge that points to or from the committing unit, so the freed unit can be issued to again on the next cycle.

Top module: `depmat_scoreboard`

## Requirements
- R1: While reset is asserted and after it is released with no issue request, go_read, go_write and issue_stall are all low.
- R2: Kind k owns units k*(NUM_FU/NUM_KIND) up to (k+1)*(NUM_FU/NUM_KIND)-1. An accepted request raises exactly one bit of issue_grant, for the lowest-numbered free unit of the requested kind, in the same cycle as issue_valid.
- R3: issue_stall is high and issue_grant is zero when issue_valid is high and every unit of the requested kind is busy.
- R4: issue_stall is high when issue_valid is high and a busy unit has the same destination register as the request.
- R5: A unit gets exactly one go_read pulse per issue, no earlier than the cycle after its issue. The pulse is withheld while an older busy unit still has to write one of its source registers.
- R6: go_write for a unit is a one-cycle pulse that comes only after its go_read, only while its result_ready input is high, and only once every older unit that reads its destination register has had its go_read.
- R7: While wr_hold for a unit is high, that unit gets no go_write and stays busy. Its go_read and the grants of other units are unaffected.
- R8: A unit that gets go_write is free from the next cycle, can be granted again by issue, and releases every unit waiting on it, so that they can be granted from that next cycle.
- R9: For any mix of unit latencies and write holds, every committed value and the final register contents equal those of executing the same instructions one at a time in issue order.
- R10: An issue accepted in the same cycle as an older unit's go_write to one of the new sources does not wait on that unit. The new unit gets go_read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | An instruction is offered for issue |
| issue_kind | input | $clog2(NUM_KIND) | Unit kind the instruction needs |
| issue_dst | input | $clog2(NUM_REG) | Destination register number |
| issue_src_a | input | $clog2(NUM_REG) | First source register number |
| issue_src_b | input | $clog2(NUM_REG) | Second source register number |
| issue_stall | output | 1 | Request cannot be accepted this cycle |
| issue_grant | output | NUM_FU | One-hot unit that takes the request this cycle |
| result_ready | input | NUM_FU | Per unit: its result is available |
| wr_hold | input | NUM_FU | Per unit: keep the write commit back |
| go_read | output | NUM_FU | Per unit: read operands now |
| go_write | output | NUM_FU | Per unit: commit the result now |

## Verification
Two grants can meet in one cycle. One is an issue whose source an older unit is committing in that very cycle. The other is a write commit that lands in the same cycle as the read grant of the unit it was waiting for. The bench keeps a unit's commit back with wr_hold and lets it go on the exact negative edge where it also offers a new instruction that reads that register. It then requires that the commit cycle equals the accept cycle and that the new unit reads one cycle later. A write-after-read case is built the same way: a write is released early, it must stay quiet until the reader's grant, and it must come exactly one cycle after that grant. A random stream with varied latencies and holds is compared value by value against an in-order model.

// File: rtl/dm_pkg.sv
`timescale 1ns/1ps
package dm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WAIT_RD = 2'd1,
    PH_EXEC    = 2'd2
  } phase_e;

  // unit number -> kind it serves (kinds own equal contiguous slices)
  function automatic int kind_of(input int unit, input int per_kind);
    return unit / per_kind;
  endfunction

  // true when register r is one of the two sources
  function automatic logic reads_reg(input int r, input int sa, input int sb);
    return (r == sa) || (r == sb);
  endfunction

endpackage

// File: rtl/dm_alloc.sv
`timescale 1ns/1ps
module dm_alloc #(
  parameter int NUM_FU   = 4,
  parameter int NUM_REG  = 8,
  parameter int NUM_KIND = 2,
  localparam int REG_W    = $clog2(NUM_REG),
  localparam int KIND_W   = $clog2(NUM_KIND),
  localparam int PER_KIND = NUM_FU / NUM_KIND
) (
  input  logic              issue_valid,
  input  logic [KIND_W-1:0] issue_kind,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [NUM_FU-1:0] busy,
  input  logic [REG_W-1:0]  dst_q [NUM_FU],
  output logic [NUM_FU-1:0] issue_grant,
  output logic              issue_stall,
  output logic              kind_full,
  output logic              waw_hit
);
  import dm_pkg::*;

  logic [NUM_FU-1:0] free_in_kind;
  logic [NUM_FU-1:0] pick;
  logic              found;

  always_comb begin
    free_in_kind = '0;
    waw_hit      = 1'b0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (kind_of(i, PER_KIND) == int'(issue_kind) && !busy[i])
        free_in_kind[i] = 1'b1;
      if (busy[i] && dst_q[i] == issue_dst)
        waw_hit = 1'b1;
    end
  end

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (free_in_kind[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign kind_full   = !found;
  assign issue_stall = issue_valid && (kind_full || waw_hit);
  assign issue_grant = (issue_valid && !issue_stall) ? pick : '0;

endmodule

// File: rtl/dm_unit_bank.sv
`timescale 1ns/1ps
module dm_unit_bank #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FU-1:0] issue_grant,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [REG_W-1:0]  issue_src_a,
  input  logic [REG_W-1:0]  issue_src_b,
  input  logic [NUM_FU-1:0] go_read,
  input  logic [NUM_FU-1:0] go_write,
  output logic [NUM_FU-1:0] busy,
  output logic [NUM_FU-1:0] rd_pend,
  output logic [REG_W-1:0]  dst_q   [NUM_FU],
  output logic [REG_W-1:0]  src_a_q [NUM_FU],
  output logic [REG_W-1:0]  src_b_q [NUM_FU]
);
  import dm_pkg::*;

  for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
    phase_e phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phase_q    <= PH_IDLE;
        dst_q[g]   <= '0;
        src_a_q[g] <= '0;
        src_b_q[g] <= '0;
      end else if (issue_grant[g]) begin
        phase_q    <= PH_WAIT_RD;
        dst_q[g]   <= issue_dst;
        src_a_q[g] <= issue_src_a;
        src_b_q[g] <= issue_src_b;
      end else if (go_read[g]) begin
        phase_q <= PH_EXEC;
      end else if (go_write[g]) begin
        phase_q <= PH_IDLE;
      end
    end

    assign busy[g]    = (phase_q != PH_IDLE);
    assign rd_pend[g] = (phase_q == PH_WAIT_RD);
  end

endmodule

// File: rtl/dm_matrix.sv
`timescale 1ns/1ps
module dm_matrix #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FU-1:0] issue_grant,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [REG_W-1:0]  issue_src_a,
  input  logic [REG_W-1:0]  issue_src_b,
  input  logic [NUM_FU-1:0] busy,
  input  logic [NUM_FU-1:0] rd_pend,
  input  logic [REG_W-1:0]  dst_q   [NUM_FU],
  input  logic [REG_W-1:0]  src_a_q [NUM_FU],
  input  logic [REG_W-1:0]  src_b_q [NUM_FU],
  input  logic [NUM_FU-1:0] go_read,
  input  logic [NUM_FU-1:0] go_write,
  output logic [NUM_FU-1:0] raw_block,
  output logic [NUM_FU-1:0] war_block
);
  import dm_pkg::*;

  // row i = waiting unit, column j = older unit it waits on
  logic [NUM_FU-1:0] raw_q   [NUM_FU];
  logic [NUM_FU-1:0] war_q   [NUM_FU];
  logic [NUM_FU-1:0] raw_nxt [NUM_FU];
  logic [NUM_FU-1:0] war_nxt [NUM_FU];

  always_comb begin
    for (int i = 0; i < NUM_FU; i++) begin
      for (int j = 0; j < NUM_FU; j++) begin
        if (issue_grant[i] && i != j && busy[j] && !go_write[j] &&
            reads_reg(int'(dst_q[j]), int'(issue_src_a), int'(issue_src_b)))
          raw_nxt[i][j] = 1'b1;
        else if (go_write[j] || go_write[i])
          raw_nxt[i][j] = 1'b0;
        else
          raw_nxt[i][j] = raw_q[i][j];

        if (issue_grant[i] && i != j && rd_pend[j] && !go_read[j] &&
            reads_reg(int'(issue_dst), int'(src_a_q[j]), int'(src_b_q[j])))
          war_nxt[i][j] = 1'b1;
        else if (go_read[j] || go_write[j] || go_write[i])
          war_nxt[i][j] = 1'b0;
        else
          war_nxt[i][j] = war_q[i][j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FU; i++) begin
        raw_q[i] <= '0;
        war_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_FU; i++) begin
        raw_q[i] <= raw_nxt[i];
        war_q[i] <= war_nxt[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_FU; g++) begin : g_row
    assign raw_block[g] = |raw_q[g];
    assign war_block[g] = |war_q[g];
  end

endmodule

// File: rtl/depmat_scoreboard.sv
`timescale 1ns/1ps
module depmat_scoreboard #(
  parameter int NUM_FU   = 4,
  parameter int NUM_REG  = 8,
  parameter int NUM_KIND = 2,
  localparam int REG_W   = $clog2(NUM_REG),
  localparam int KIND_W  = $clog2(NUM_KIND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [KIND_W-1:0] issue_kind,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [REG_W-1:0]  issue_src_a,
  input  logic [REG_W-1:0]  issue_src_b,
  output logic              issue_stall,
  output logic [NUM_FU-1:0] issue_grant,
  input  logic [NUM_FU-1:0] result_ready,
  input  logic [NUM_FU-1:0] wr_hold,
  output logic [NUM_FU-1:0] go_read,
  output logic [NUM_FU-1:0] go_write
);

  logic [NUM_FU-1:0] busy;
  logic [NUM_FU-1:0] rd_pend;
  logic [NUM_FU-1:0] raw_block;
  logic [NUM_FU-1:0] war_block;
  logic              kind_full;
  logic              waw_hit;
  logic [REG_W-1:0]  dst_q   [NUM_FU];
  logic [REG_W-1:0]  src_a_q [NUM_FU];
  logic [REG_W-1:0]  src_b_q [NUM_FU];

  dm_alloc #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG), .NUM_KIND(NUM_KIND)) u_alloc (
    .issue_valid (issue_valid),
    .issue_kind  (issue_kind),
    .issue_dst   (issue_dst),
    .busy        (busy),
    .dst_q       (dst_q),
    .issue_grant (issue_grant),
    .issue_stall (issue_stall),
    .kind_full   (kind_full),
    .waw_hit     (waw_hit)
  );

  dm_unit_bank #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_grant (issue_grant),
    .issue_dst   (issue_dst),
    .issue_src_a (issue_src_a),
    .issue_src_b (issue_src_b),
    .go_read     (go_read),
    .go_write    (go_write),
    .busy        (busy),
    .rd_pend     (rd_pend),
    .dst_q       (dst_q),
    .src_a_q     (src_a_q),
    .src_b_q     (src_b_q)
  );

  dm_matrix #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_matrix (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_grant (issue_grant),
    .issue_dst   (issue_dst),
    .issue_src_a (issue_src_a),
    .issue_src_b (issue_src_b),
    .busy        (busy),
    .rd_pend     (rd_pend),
    .dst_q       (dst_q),
    .src_a_q     (src_a_q),
    .src_b_q     (src_b_q),
    .go_read     (go_read),
    .go_write    (go_write),
    .raw_block   (raw_block),
    .war_block   (war_block)
  );

  // grants: read once no older writer of a source remains; write once
  // executed, ready, no older reader of the destination remains, not held
  assign go_read  = rd_pend & ~raw_block;
  assign go_write = busy & ~rd_pend & result_ready & ~war_block & ~wr_hold;

endmodule

// File: rtl/depmat_scoreboard_chk.sv
`timescale 1ns/1ps
module depmat_scoreboard_chk #(
  parameter int NUM_FU = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              issue_stall,
  input logic [NUM_FU-1:0] issue_grant,
  input logic [NUM_FU-1:0] go_read,
  input logic [NUM_FU-1:0] go_write,
  input logic [NUM_FU-1:0] wr_hold,
  input logic [NUM_FU-1:0] busy,
  input logic [NUM_FU-1:0] rd_pend,
  input logic              kind_full,
  input logic              waw_hit
);

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_grant));

  assert_grant_takes_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|issue_grant) |=> ((busy & $past(issue_grant)) == $past(issue_grant)));

  assert_grant_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant & busy) == '0);

  assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && kind_full) |-> (issue_stall && issue_grant == '0));

  assert_waw_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && waw_hit) |-> issue_stall);

  assert_read_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|go_read) |=> ((go_read & $past(go_read)) == '0));

  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|go_write) |-> ((go_write & $past(rd_pend) & ~$past(go_read)) == '0));

  assert_read_write_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_read & go_write) == '0);

  assert_hold_keeps_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wr_hold & busy)) |=> ((busy & $past(wr_hold & busy)) == $past(wr_hold & busy)));

  assert_free_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|go_write) |=> ((busy & $past(go_write)) == '0));

endmodule

bind depmat_scoreboard depmat_scoreboard_chk #(.NUM_FU(NUM_FU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_stall (issue_stall),
  .issue_grant (issue_grant),
  .go_read     (go_read),
  .go_write    (go_write),
  .wr_hold     (wr_hold),
  .busy        (busy),
  .rd_pend     (rd_pend),
  .kind_full   (kind_full),
  .waw_hit     (waw_hit)
);

// File: tb/depmat_scoreboard_tb.sv
`timescale 1ns/1ps
module depmat_scoreboard_tb;

  localparam int NFU  = 4;
  localparam int NREG = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            issue_valid = 1'b0;
  logic [0:0]      issue_kind = '0;
  logic [2:0]      issue_dst = '0, issue_src_a = '0, issue_src_b = '0;
  logic            issue_stall;
  logic [NFU-1:0]  issue_grant;
  logic [NFU-1:0]  result_ready = '0;
  logic [NFU-1:0]  wr_hold = '0;
  logic [NFU-1:0]  go_read, go_write;

  depmat_scoreboard #(.NUM_FU(NFU), .NUM_REG(NREG), .NUM_KIND(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_kind(issue_kind),
    .issue_dst(issue_dst), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
    .issue_stall(issue_stall), .issue_grant(issue_grant),
    .result_ready(result_ready), .wr_hold(wr_hold),
    .go_read(go_read), .go_write(go_write)
  );

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0, fails = 0;
  int cyc = 0;
  int outstanding = 0;
  bit rand_on = 0;

  // per-unit records filled by the driver
  int        rec_dst [NFU], rec_sa [NFU], rec_sb [NFU], rec_lat [NFU];
  logic [15:0] rec_tag [NFU];
  logic [15:0] opa [NFU], opb [NFU];
  int        cnt [NFU];
  bit        active [NFU];
  int        rd_cnt [NFU], wr_cnt [NFU], rd_cyc [NFU], wr_cyc [NFU];
  logic [15:0] arch [NREG];     // register file as the units see it
  logic [15:0] ref_r [NREG];    // in-order model
  logic [15:0] exp_q [NFU][$];
  logic [15:0] next_tag = 16'd1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // function-unit models and commit monitor
  initial begin
    for (int r = 0; r < NREG; r++) begin
      arch[r]  = 16'(r * 3 + 1);
      ref_r[r] = 16'(r * 3 + 1);
    end
    for (int i = 0; i < NFU; i++) begin
      active[i] = 0; cnt[i] = 0; rd_cnt[i] = 0; wr_cnt[i] = 0;
      rd_cyc[i] = -1; wr_cyc[i] = -1;
    end
    forever begin
      @(negedge clk);
      if (rand_on) wr_hold = NFU'($urandom() & $urandom());
      for (int i = 0; i < NFU; i++) begin
        if (active[i] && cnt[i] > 0) cnt[i]--;
        result_ready[i] = active[i] && cnt[i] == 0;
      end
      #3;
      for (int i = 0; i < NFU; i++) begin
        if (go_read[i]) begin
          opa[i] = arch[rec_sa[i]];
          opb[i] = arch[rec_sb[i]];
          active[i] = 1; cnt[i] = rec_lat[i];
          rd_cnt[i]++; rd_cyc[i] = cyc;
        end
      end
      for (int i = 0; i < NFU; i++) begin
        if (go_write[i]) begin
          logic [15:0] v;
          v = opa[i] + opb[i] + rec_tag[i];
          if (exp_q[i].size() == 0) begin
            chk("R9 commit with nothing expected", i, -1);
          end else begin
            logic [15:0] e;
            e = exp_q[i].pop_front();
            chk($sformatf("R9 committed value unit %0d", i), int'(v), int'(e));
          end
          arch[rec_dst[i]] = v;
          active[i] = 0;
          wr_cnt[i]++; wr_cyc[i] = cyc;
          outstanding--;
        end
      end
    end
  end

  // driver: offer until accepted, push the in-order expected result
  task automatic do_issue(input int k, input int d, input int a, input int b,
                          input int lat, input int rel,
                          output logic [NFU-1:0] g, output int acc);
    bit done = 0;
    @(negedge clk);
    if (rel >= 0) wr_hold[rel] = 1'b0;
    issue_valid = 1'b1; issue_kind = 1'(k);
    issue_dst = 3'(d); issue_src_a = 3'(a); issue_src_b = 3'(b);
    while (!done) begin
      #1;
      if (!issue_stall) begin
        done = 1;
        g = issue_grant;
        acc = cyc;
        for (int i = 0; i < NFU; i++) begin
          if (issue_grant[i]) begin
            logic [15:0] e;
            rec_dst[i] = d; rec_sa[i] = a; rec_sb[i] = b; rec_lat[i] = lat;
            rec_tag[i] = next_tag;
            e = ref_r[a] + ref_r[b] + next_tag;
            ref_r[d] = e;
            exp_q[i].push_back(e);
            outstanding++;
          end
        end
        next_tag++;
      end else begin
        @(negedge clk);
      end
    end
    @(posedge clk);
    #1 issue_valid = 1'b0;
  endtask

  task automatic try_stall(input int k, input int d, input int a, input int b,
                           output logic s, output logic [NFU-1:0] g);
    @(negedge clk);
    issue_valid = 1'b1; issue_kind = 1'(k);
    issue_dst = 3'(d); issue_src_a = 3'(a); issue_src_b = 3'(b);
    #1;
    s = issue_stall; g = issue_grant;
    #1 issue_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired: got 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    logic [NFU-1:0] g;
    logic s;
    int acc;

    // R1 reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1 go_read in reset", int'(go_read), 0);
    chk("R1 go_write in reset", int'(go_write), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 stall idle", int'(issue_stall), 0);
    chk("R1 go_read idle", int'(go_read), 0);

    // directed hazards, commits held
    wr_hold = '1;
    do_issue(0, 1, 2, 3, 2, -1, g, acc);
    chk("R2 first kind0 grant", int'(g), 1);
    do_issue(0, 4, 1, 0, 2, -1, g, acc);     // reads r1 written by unit 0
    chk("R2 second kind0 grant", int'(g), 2);
    try_stall(0, 5, 6, 7, s, g);
    chk("R3 kind0 full stall", int'(s), 1);
    chk("R3 kind0 full grant", int'(g), 0);
    try_stall(1, 1, 6, 7, s, g);
    chk("R4 same destination stall", int'(s), 1);
    do_issue(1, 0, 5, 6, 1, -1, g, acc);     // writes r0 read by unit 1
    chk("R2 first kind1 grant", int'(g), 4);
    repeat (10) @(negedge clk);
    chk("R5 reader waits on pending writer", rd_cnt[1], 0);
    chk("R7 held unit still reads", rd_cnt[0], 1);
    chk("R7 held unit does not commit", wr_cnt[0], 0);
    chk("R7 held unit ready", int'(result_ready[0]), 1);

    @(negedge clk);
    wr_hold[2] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 writer waits on older reader", wr_cnt[2], 0);

    @(negedge clk);
    wr_hold[0] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 released unit commits", wr_cnt[0], 1);
    chk("R8 waiter reads next cycle", rd_cyc[1], wr_cyc[0] + 1);
    chk("R6 write one cycle after reader", wr_cyc[2], rd_cyc[1] + 1);

    do_issue(0, 7, 4, 4, 1, -1, g, acc);     // unit 0 reused, waits on unit 1
    chk("R8 freed unit granted again", int'(g), 1);
    repeat (4) @(negedge clk);

    // R10: release unit 1 commit in the same cycle as issue reading r4
    do_issue(1, 6, 4, 2, 1, 1, g, acc);
    chk("R10 same-cycle issue grant", int'(g), 4);
    repeat (4) @(negedge clk);
    chk("R10 commit in accept cycle", wr_cyc[1], acc);
    chk("R10 new unit reads next cycle", rd_cyc[2], acc + 1);
    chk("R8 earlier waiter reads next cycle", rd_cyc[0], acc + 1);

    wr_hold = '0;
    while (outstanding != 0) @(negedge clk);

    // random stream with varied latency and holds
    rand_on = 1;
    for (int n = 0; n < 250; n++) begin
      do_issue(int'($urandom() % 2), int'($urandom() % NREG), int'($urandom() % NREG),
               int'($urandom() % NREG), int'($urandom() % 7), -1, g, acc);
    end
    rand_on = 0;
    @(negedge clk);
    wr_hold = '0;
    while (outstanding != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    for (int r = 0; r < NREG; r++)
      chk($sformatf("R9 final register %0d", r), int'(arch[r]), int'(ref_r[r]));
    #1;
    chk("R1 quiet after drain", int'(go_read | go_write), 0);

    summary();
    $finish;
  end

endmodule